// File: doc/BRIEF.md
# Two-Address I2C Slave with Command and Data Channels

This block is an I2C target that answers two 7-bit bus addresses and routes the traffic by address. The first address is a write-only command channel: every byte the controller writes after it is acknowledged and passed to internal logic with a command strobe. The second address is a data channel. A write to it delivers bytes with a separate write strobe. A read from it pulls bytes from internal logic one at a time, and the block shifts them out until the controller answers a byte with NACK.

SCL and SDA are brought into a fast system clock through synchronizers, and all framing is derived from the sampled levels. START, repeated START and STOP are found from SDA edges while SCL is high. The block only pulls SDA low through an open-drain enable and never stretches the clock. The byte delivered on a read must be held steady from the read request until the falling SCL edge that starts that byte.

Top module: `i2c_cmd_data_slave`

## Requirements
- R1: After a START and the address byte 0x36 (address 0011011, R/W = 0), the block pulls SDA low in the ninth clock. Every following byte is acknowledged and shows up on `rx_byte_o` with a one-cycle `cmd_stb_o`. The first bit on the bus is bit 7 of the byte.
- R2: The address byte 0x37 (command address with R/W = 1) is not acknowledged. Until the next START or STOP, SDA stays released, and no strobe and no read request is raised.
- R3: After the address byte 0x34 (address 0011010, R/W = 0), every byte is acknowledged and shows up on `rx_byte_o` with a one-cycle `wr_stb_o`. `cmd_stb_o` and `wr_stb_o` are never high together.
- R4: After the address byte 0x35 (data address, R/W = 1), the block acknowledges it and pulses `rd_req_o` for one cycle. It then drives the byte present on `rd_byte_i` at the next falling SCL edge onto the bus, bit 7 first. SDA changes only while SCL is low.
- R5: In a read, a controller ACK (SDA low in the ninth clock) leads to a new `rd_req_o` pulse and a new byte. A controller NACK makes the block release SDA, and it raises no further `rd_req_o` until the next START or STOP.
- R6: A repeated START begins a new address phase at once, without a STOP. A STOP returns the block to idle with SDA released.
- R7: An address byte that matches neither address gets no ACK. SDA then stays released for the rest of the transaction, and no strobe or read request is raised.
- R8: The block's own ACK holds SDA low for exactly the ninth SCL high period. The drive comes on after the eighth falling edge and is gone within a few system cycles of the ninth falling edge.
- R9: During and just after reset, `sda_drive_o`, `cmd_stb_o`, `wr_stb_o` and `rd_req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL wire |
| sda_i | input | 1 | Sampled level of the SDA wire |
| sda_drive_o | output | 1 | When high, the SDA wire is pulled low |
| cmd_stb_o | output | 1 | One-cycle strobe: `rx_byte_o` holds a command byte |
| wr_stb_o | output | 1 | One-cycle strobe: `rx_byte_o` holds a data write byte |
| rx_byte_o | output | 8 | Last received byte |
| rd_req_o | output | 1 | One-cycle request for the next byte to send |
| rd_byte_i | input | 8 | Byte to send, valid from the request to the next SCL fall |

## Verification
The hardest case to reach is the end of a read. The controller has to NACK the last byte and then keep clocking, so that it shows the block has let go of SDA and raises no further request before STOP. A second hard case is a repeated START that follows a command byte, which switches the block straight into a read. The bench is a bit-level bus controller with its own SDA wired-AND, so it can script both sequences. It also sweeps every 7-bit address with a write bit to confirm that only the two expected ones get an ACK.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } eng_state_e;

    typedef struct packed {
        eng_state_e st;
        logic [7:0] sh;
        logic [3:0] cnt;
        logic       is_read;
        logic       is_cmd;
        logic       oe;
        logic       cmd_v;
        logic       wr_v;
        logic       rd_r;
        logic [7:0] rx;
    } eng_regs_t;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_raw_i,
    input  logic sda_raw_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0][STAGES-1:0] chain_d, chain_q;
    logic [NLINES-1:0]             prev_d, prev_q;
    logic [NLINES-1:0]             raw;
    logic [NLINES-1:0]             cur;

    assign raw = {sda_raw_i, scl_raw_i};

    // one synchronizer chain per bus line
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        if (STAGES == 1) begin : g_one
            assign chain_d[g] = raw[g];
        end else begin : g_many
            assign chain_d[g] = {chain_q[g][STAGES-2:0], raw[g]};
        end
        assign cur[g]    = chain_q[g][STAGES-1];
        assign prev_d[g] = cur[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '1;
            prev_q  <= '1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign scl_s_o    = cur[0];
    assign sda_s_o    = cur[1];
    assign scl_rise_o = cur[0] & ~prev_q[0];
    assign scl_fall_o = ~cur[0] & prev_q[0];
    assign start_o    = cur[0] & prev_q[0] & prev_q[1] & ~cur[1];
    assign stop_o     = cur[0] & prev_q[0] & ~prev_q[1] & cur[1];

    p_start_stop_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(start_o && stop_o));

    p_edge_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(scl_rise_o && scl_fall_o));

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter logic [6:0] CMD_ADDR  = 7'b0011011,
    parameter logic [6:0] DATA_ADDR = 7'b0011010
) (
    input  logic [7:0] addr_byte_i,
    output logic       accept_o,
    output logic       to_cmd_o,
    output logic       is_read_o
);
    logic hit_cmd, hit_data;

    always_comb begin
        hit_cmd   = (addr_byte_i[7:1] == CMD_ADDR);
        hit_data  = (addr_byte_i[7:1] == DATA_ADDR);
        is_read_o = addr_byte_i[0];
        to_cmd_o  = hit_cmd;
        // command channel takes writes only
        accept_o  = hit_data | (hit_cmd & ~addr_byte_i[0]);
    end

    initial begin
        a_addr_distinct: assert (CMD_ADDR != DATA_ADDR);
    end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_slave_pkg::*;
#(
    parameter logic [6:0] CMD_ADDR  = 7'b0011011,
    parameter logic [6:0] DATA_ADDR = 7'b0011010
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       scl_s_i,
    input  logic       sda_s_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic [7:0] rd_byte_i,
    output logic       sda_drive_o,
    output logic       cmd_stb_o,
    output logic       wr_stb_o,
    output logic [7:0] rx_byte_o,
    output logic       rd_req_o
);
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;
    localparam logic [3:0] LAST_TX_BIT   = BITS_PER_BYTE - 4'd1;

    eng_regs_t d, q;
    logic      accept, to_cmd, is_read;

    i2c_addr_match #(
        .CMD_ADDR (CMD_ADDR),
        .DATA_ADDR(DATA_ADDR)
    ) u_match (
        .addr_byte_i(q.sh),
        .accept_o   (accept),
        .to_cmd_o   (to_cmd),
        .is_read_o  (is_read)
    );

    always_comb begin
        d       = q;
        d.cmd_v = 1'b0;
        d.wr_v  = 1'b0;
        d.rd_r  = 1'b0;
        if (stop_i) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_i) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        d.sh  = {q.sh[6:0], sda_s_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && q.cnt == BITS_PER_BYTE) begin
                        if (accept) begin
                            d.oe      = 1'b1;
                            d.is_read = is_read;
                            d.is_cmd  = to_cmd;
                            d.rd_r    = is_read;
                            d.st      = ST_ACK;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        d.cnt = '0;
                        if (q.is_read) begin
                            d.sh = rd_byte_i;
                            d.oe = ~rd_byte_i[7];
                            d.st = ST_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_RX;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise_i) begin
                        d.sh  = {q.sh[6:0], sda_s_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && q.cnt == BITS_PER_BYTE) begin
                        d.oe    = 1'b1;
                        d.rx    = q.sh;
                        d.cmd_v = q.is_cmd;
                        d.wr_v  = ~q.is_cmd;
                        d.st    = ST_ACK;
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (q.cnt == LAST_TX_BIT) begin
                            d.oe = 1'b0;
                            d.st = ST_TX_ACK;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.oe  = ~q.sh[6];
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise_i) begin
                        if (!sda_s_i) begin
                            d.rd_r = 1'b1;
                            d.st   = ST_ACK;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                ST_IGNORE: ;
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q         <= '0;
            q.st      <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_drive_o = q.oe;
    assign cmd_stb_o   = q.cmd_v;
    assign wr_stb_o    = q.wr_v;
    assign rx_byte_o   = q.rx;
    assign rd_req_o    = q.rd_r;

    p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cmd_stb_o && wr_stb_o));

    p_cmd_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_stb_o |=> !cmd_stb_o);

    p_wr_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stb_o |=> !wr_stb_o);

    p_rdreq_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_o |=> !rd_req_o);

    // drive only changes while SCL is low, apart from a forced release on framing
    p_sda_low_scl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sda_drive_o != $past(sda_drive_o)) && !$past(start_i || stop_i) |-> !scl_s_i);

    p_ignore_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_IGNORE) |-> (!sda_drive_o && !rd_req_o && !cmd_stb_o && !wr_stb_o));

    p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_IDLE) |-> !sda_drive_o);

    p_ack_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_ACK) && !q.is_read && scl_fall_i && !start_i && !stop_i |=> !sda_drive_o);

endmodule

// File: rtl/i2c_cmd_data_slave.sv
module i2c_cmd_data_slave #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] CMD_ADDR    = 7'b0011011,
    parameter logic [6:0] DATA_ADDR   = 7'b0011010
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_o,
    output logic       cmd_stb_o,
    output logic       wr_stb_o,
    output logic [7:0] rx_byte_o,
    output logic       rd_req_o,
    input  logic [7:0] rd_byte_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .scl_raw_i (scl_i),
        .sda_raw_i (sda_i),
        .scl_s_o   (scl_s),
        .sda_s_o   (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    i2c_byte_engine #(
        .CMD_ADDR (CMD_ADDR),
        .DATA_ADDR(DATA_ADDR)
    ) u_engine (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_s_i    (scl_s),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .rd_byte_i  (rd_byte_i),
        .sda_drive_o(sda_drive_o),
        .cmd_stb_o  (cmd_stb_o),
        .wr_stb_o   (wr_stb_o),
        .rx_byte_o  (rx_byte_o),
        .rd_req_o   (rd_req_o)
    );

endmodule

// File: tb/i2c_cmd_data_slave_tb_top.sv
module i2c_cmd_data_slave_tb_top;
    localparam int Q = 10;
    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_drive, cmd_stb, wr_stb, rd_req;
    logic [7:0] rx_byte;
    logic [7:0] rd_byte = 8'h00;
    wire        sda_line = sda_m & ~sda_drive;

    int checks = 0;
    int fails  = 0;
    int cmd_n = 0, wr_n = 0, rd_n = 0;
    logic [7:0] cmd_log [16];
    logic [7:0] wr_log  [16];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_cmd_data_slave dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_drive_o(sda_drive),
        .cmd_stb_o  (cmd_stb),
        .wr_stb_o   (wr_stb),
        .rx_byte_o  (rx_byte),
        .rd_req_o   (rd_req),
        .rd_byte_i  (rd_byte)
    );

    function automatic logic [7:0] rd_val(int idx);
        return (8'(idx) * 8'd29 + 8'h3C) ^ 8'h81;
    endfunction

    // monitors and read responder, away from the active edge
    always @(negedge clk) begin
        if (cmd_stb) begin
            if (cmd_n < 16) cmd_log[cmd_n] = rx_byte;
            cmd_n++;
        end
        if (wr_stb) begin
            if (wr_n < 16) wr_log[wr_n] = rx_byte;
            wr_n++;
        end
        if (rd_req) begin
            rd_byte = rd_val(rd_n);
            rd_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked, output bit released);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(H/2);
        acked = !sda_line;
        tick(H/2);
        scl_m = 1'b0; tick(Q);
        released = !sda_drive;
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(H/2);
            b[i] = sda_line;
            tick(H/2);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = nack; tick(Q);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        bit ack, rel;
        logic [7:0] b;
        int c0, w0, r0;

        tick(4);
        // R9: outputs quiet in reset
        chk(!sda_drive && !cmd_stb && !wr_stb && !rd_req, "R9 in reset",
            {sda_drive, cmd_stb, wr_stb, rd_req}, 0);
        rst_n = 1'b1;
        tick(8);
        chk(!sda_drive && !cmd_stb && !wr_stb && !rd_req, "R9 after reset",
            {sda_drive, cmd_stb, wr_stb, rd_req}, 0);

        // R7/R1/R3: sweep of all addresses with the write bit
        for (int a = 0; a < 128; a++) begin
            bit exp_ack;
            exp_ack = (a == 7'b0011011) || (a == 7'b0011010);
            bus_start();
            send_byte({7'(a), 1'b0}, ack, rel);
            chk(ack == exp_ack, exp_ack ? "R1/R3 address ack" : "R7 foreign address nack", ack, exp_ack);
            bus_stop();
        end
        chk(cmd_n == 0 && wr_n == 0 && rd_n == 0, "R7 no strobes from addressing",
            cmd_n + wr_n + rd_n, 0);

        // R7: foreign address followed by a byte stays silent
        bus_start();
        send_byte(8'hA0, ack, rel);
        chk(!ack, "R7 foreign nack", ack, 0);
        send_byte(8'h00, ack, rel);
        chk(!ack && wr_n == 0 && cmd_n == 0, "R7 byte after foreign address ignored", ack, 0);
        bus_stop();

        // R2: read on command address refused
        bus_start();
        send_byte(8'h37, ack, rel);
        chk(!ack, "R2 command read nack", ack, 0);
        r0 = rd_n;
        recv_byte(1'b1, b);
        chk(b == 8'hFF && rd_n == r0, "R2 bus released, no request", b, 8'hFF);
        bus_stop();

        // R1/R8: command stream
        bus_start();
        send_byte(8'h36, ack, rel);
        chk(ack && rel, "R8 command address ack window", {ack, rel}, 3);
        for (int i = 0; i < 6; i++) begin
            send_byte(8'(i * 53 + 7), ack, rel);
            chk(ack && rel, "R1 command byte ack", {ack, rel}, 3);
        end
        bus_stop();
        chk(cmd_n == 6 && wr_n == 0, "R1 command strobe count", cmd_n, 6);
        for (int i = 0; i < 6; i++)
            chk(cmd_log[i] == 8'(i * 53 + 7), "R1 command byte value", cmd_log[i], 8'(i * 53 + 7));
        chk(!sda_drive, "R6 idle after stop", sda_drive, 0);

        // R3: data writes
        bus_start();
        send_byte(8'h34, ack, rel);
        chk(ack, "R3 data write address ack", ack, 1);
        for (int i = 0; i < 5; i++) begin
            send_byte(8'(8'hF0 - i * 37), ack, rel);
            chk(ack && rel, "R3 data byte ack", {ack, rel}, 3);
        end
        bus_stop();
        chk(wr_n == 5 && cmd_n == 6, "R3 write strobe count", wr_n, 5);
        for (int i = 0; i < 5; i++)
            chk(wr_log[i] == 8'(8'hF0 - i * 37), "R3 write byte value", wr_log[i], 8'(8'hF0 - i * 37));

        // R4/R5: read of four bytes, NACK on the last
        bus_start();
        r0 = rd_n;
        send_byte(8'h35, ack, rel);
        chk(ack, "R4 data read address ack", ack, 1);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i == 3, b);
            chk(b == rd_val(r0 + i), "R4 read byte value", b, rd_val(r0 + i));
        end
        chk(rd_n == r0 + 4, "R5 request count", rd_n - r0, 4);
        recv_byte(1'b1, b);
        chk(b == 8'hFF && rd_n == r0 + 4, "R5 released after nack", b, 8'hFF);
        bus_stop();

        // R6: command then repeated START into a read
        c0 = cmd_n; w0 = wr_n;
        bus_start();
        send_byte(8'h36, ack, rel);
        send_byte(8'hC3, ack, rel);
        chk(ack, "R6 command before repeated start", ack, 1);
        r0 = rd_n;
        bus_start();
        send_byte(8'h35, ack, rel);
        chk(ack, "R6 address after repeated start", ack, 1);
        recv_byte(1'b1, b);
        chk(b == rd_val(r0), "R6 read after repeated start", b, rd_val(r0));
        bus_stop();
        chk(cmd_n == c0 + 1 && cmd_log[c0] == 8'hC3 && wr_n == w0, "R6 command kept",
            cmd_log[c0], 8'hC3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule